// File: doc/BRIEF.md
# Loopback and All-Ones Line Path Selector

This block sits between the transmit-side bit stream, the receive-side bit stream and the line encoder/decoder of a dual-rail (positive/negative) line interface. In its normal state the transmit bits go to the line driver rails and the decoded line bits go to the receive outputs. Two independent controls change that routing. Loopback sends the transmit bits to the receive outputs in place of the line bits, while the line driver keeps sending them. All-ones replaces only what goes to the line driver with a continuous mark pattern of alternating polarity, one mark per transmit bit.

Everything runs on one system clock. A bit arrives as a one-cycle `valid` strobe carrying two rails; the strobe rate is the transmit clock. The line runs at a fixed rate, so there is no `ready` and no back-pressure: a strobe is always taken, and each output strobe appears exactly one clock after the strobe that caused it. The rails of each output hold their last value between strobes. Both controls can come from dedicated pins or from a host control byte, and a mode change is adopted only on a transmit bit, so that no bit on the line is ever cut short.

Top module: `lbk_path_sel`

## Requirements
- R1: After reset all outputs are low, loopback and all-ones are both off, and the first all-ones mark is positive.
- R2: With `hw_mode` high the controls are `pin_loop` and `pin_ones`; with `hw_mode` low they are `host_ctrl` bit 6 (loopback) and bit 5 (all-ones), and the pins have no effect.
- R3: A control change is adopted only on a clock with `tx_valid` high and applies to that bit; between transmit bits the routing stays as it was.
- R4: With loopback off, `rx_valid`/`rx_pos`/`rx_neg` show `line_valid`/`line_pos`/`line_neg` one clock later.
- R5: With loopback on, `rx_valid`/`rx_pos`/`rx_neg` show `tx_valid`/`tx_pos`/`tx_neg` one clock later and the line inputs have no effect on them.
- R6: With all-ones off, `drv_valid`/`drv_pos`/`drv_neg` show `tx_valid`/`tx_pos`/`tx_neg` one clock later, in loopback as well.
- R7: With all-ones on, each transmit bit gives `drv_valid` with exactly one rail high, the rail alternating from bit to bit.
- R8: The first all-ones mark has the polarity opposite to the last single-rail mark sent to the line (data or all-ones); a bit with both rails or none does not change it.
- R9: Loopback and all-ones together give transmit data on the receive outputs and the all-ones pattern on the driver outputs.
- R10: All-ones has no effect on the receive outputs.
- R11: Between strobes `rx_valid` and `drv_valid` are low and the rails keep the value of the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hw_mode | input | 1 | 1: controls from pins, 0: from host byte |
| pin_loop | input | 1 | Loopback request pin, high active |
| pin_ones | input | 1 | All-ones request pin, high active |
| host_ctrl | input | 8 | Host control byte (bit 6 loopback, bit 5 all-ones) |
| tx_valid | input | 1 | Transmit bit strobe |
| tx_pos | input | 1 | Transmit positive rail |
| tx_neg | input | 1 | Transmit negative rail |
| line_valid | input | 1 | Decoded line bit strobe |
| line_pos | input | 1 | Decoded line positive rail |
| line_neg | input | 1 | Decoded line negative rail |
| rx_valid | output | 1 | Receive bit strobe |
| rx_pos | output | 1 | Receive positive rail |
| rx_neg | output | 1 | Receive negative rail |
| drv_valid | output | 1 | Line driver bit strobe |
| drv_pos | output | 1 | Line driver positive rail |
| drv_neg | output | 1 | Line driver negative rail |

## Verification
A wrong adopted mode shows on the very next strobe: a loopback flag in error puts line bits on the receive rails (or transmit bits), and an all-ones flag in error sends data instead of a mark, each visible one clock after the transmit strobe. A wrong polarity memory shows as two marks of the same sign in a row, or a first all-ones mark of the wrong sign, on the first all-ones bit after the error. A mode flag that moves between strobes shows on the next line-only strobe, whose receive output takes the wrong source.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } rail_t;

  localparam rail_t RAIL_IDLE = '{pos: 1'b0, neg: 1'b0};

  function automatic logic is_mark(input rail_t r);
    return r.pos ^ r.neg;
  endfunction
endpackage

// File: rtl/lbk_ctrl_sel.sv
module lbk_ctrl_sel #(
  parameter int CTRL_W   = 8,
  parameter int LOOP_BIT = 6,
  parameter int ONES_BIT = 5
) (
  input  logic              hw_mode,
  input  logic              pin_loop,
  input  logic              pin_ones,
  input  logic [CTRL_W-1:0] host_ctrl,
  output logic              req_loop,
  output logic              req_ones
);
  always_comb begin
    if (hw_mode) begin
      req_loop = pin_loop;
      req_ones = pin_ones;
    end else begin
      req_loop = host_ctrl[LOOP_BIT];
      req_ones = host_ctrl[ONES_BIT];
    end
  end
endmodule

// File: rtl/lbk_mode_reg.sv
module lbk_mode_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic req_loop,
  input  logic req_ones,
  output logic loop_nx,
  output logic ones_nx,
  output logic loop_q,
  output logic ones_q
);
  // Requests are adopted only on a transmit bit; the adopted value
  // governs that same bit.
  assign loop_nx = bit_en ? req_loop : loop_q;
  assign ones_nx = bit_en ? req_ones : ones_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      ones_q <= 1'b0;
    end else begin
      loop_q <= loop_nx;
      ones_q <= ones_nx;
    end
  end
endmodule

// File: rtl/lbk_ones_gen.sv
module lbk_ones_gen
  import lbk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_en,
  input  logic  ones_nx,
  input  rail_t tx_data,
  output rail_t line_nx
);
  logic last_pos_q;

  always_comb begin
    if (ones_nx) begin
      line_nx.pos = ~last_pos_q;
      line_nx.neg = last_pos_q;
    end else begin
      line_nx = tx_data;
    end
  end

  // Remember the sign of the last single-rail mark put on the line.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
    end else if (bit_en && is_mark(line_nx)) begin
      last_pos_q <= line_nx.pos;
    end
  end
endmodule

// File: rtl/lbk_route.sv
module lbk_route
  import lbk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  loop_nx,
  input  logic  tx_valid,
  input  rail_t tx_data,
  input  logic  line_valid,
  input  rail_t line_data,
  input  rail_t drv_nx,
  output logic  rx_valid,
  output rail_t rx_data,
  output logic  drv_valid,
  output rail_t drv_data
);
  logic  sel_valid;
  rail_t sel_data;

  always_comb begin
    if (loop_nx) begin
      sel_valid = tx_valid;
      sel_data  = tx_data;
    end else begin
      sel_valid = line_valid;
      sel_data  = line_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_data   <= RAIL_IDLE;
      drv_valid <= 1'b0;
      drv_data  <= RAIL_IDLE;
    end else begin
      rx_valid  <= sel_valid;
      drv_valid <= tx_valid;
      if (sel_valid) rx_data  <= sel_data;
      if (tx_valid)  drv_data <= drv_nx;
    end
  end
endmodule

// File: rtl/lbk_path_sel.sv
module lbk_path_sel
  import lbk_pkg::*;
#(
  parameter int CTRL_W   = 8,
  parameter int LOOP_BIT = 6,
  parameter int ONES_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_mode,
  input  logic              pin_loop,
  input  logic              pin_ones,
  input  logic [CTRL_W-1:0] host_ctrl,
  input  logic              tx_valid,
  input  logic              tx_pos,
  input  logic              tx_neg,
  input  logic              line_valid,
  input  logic              line_pos,
  input  logic              line_neg,
  output logic              rx_valid,
  output logic              rx_pos,
  output logic              rx_neg,
  output logic              drv_valid,
  output logic              drv_pos,
  output logic              drv_neg
);
  logic  req_loop, req_ones;
  logic  loop_nx, ones_nx, loop_q, ones_q;
  rail_t tx_data, line_data, drv_nx, rx_data, drv_data;

  assign tx_data   = '{pos: tx_pos, neg: tx_neg};
  assign line_data = '{pos: line_pos, neg: line_neg};

  lbk_ctrl_sel #(.CTRL_W(CTRL_W), .LOOP_BIT(LOOP_BIT), .ONES_BIT(ONES_BIT)) u_ctrl (
    .hw_mode(hw_mode), .pin_loop(pin_loop), .pin_ones(pin_ones),
    .host_ctrl(host_ctrl), .req_loop(req_loop), .req_ones(req_ones)
  );

  lbk_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .bit_en(tx_valid),
    .req_loop(req_loop), .req_ones(req_ones),
    .loop_nx(loop_nx), .ones_nx(ones_nx), .loop_q(loop_q), .ones_q(ones_q)
  );

  lbk_ones_gen u_ones (
    .clk(clk), .rst_n(rst_n), .bit_en(tx_valid), .ones_nx(ones_nx),
    .tx_data(tx_data), .line_nx(drv_nx)
  );

  lbk_route u_route (
    .clk(clk), .rst_n(rst_n), .loop_nx(loop_nx),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .line_valid(line_valid), .line_data(line_data), .drv_nx(drv_nx),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .drv_valid(drv_valid), .drv_data(drv_data)
  );

  assign rx_pos  = rx_data.pos;
  assign rx_neg  = rx_data.neg;
  assign drv_pos = drv_data.pos;
  assign drv_neg = drv_data.neg;
endmodule

// File: rtl/lbk_checker.sv
module lbk_checker (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_pos,
  input logic tx_neg,
  input logic line_valid,
  input logic rx_valid,
  input logic rx_pos,
  input logic drv_valid,
  input logic drv_pos,
  input logic drv_neg,
  input logic loop_q,
  input logic ones_q
);
  logic past_ok;
  logic seen_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok  <= 1'b0;
      seen_pos <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      if (drv_valid && (drv_pos ^ drv_neg)) seen_pos <= drv_pos;
    end
  end

  assert_drv_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (drv_valid == $past(tx_valid)));

  assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(tx_valid)) |-> ($stable(loop_q) && $stable(ones_q)));

  assert_loop_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && loop_q) |-> (rx_valid == $past(tx_valid)));

  assert_loop_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && loop_q && rx_valid) |-> (rx_pos == $past(tx_pos)));

  assert_line_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !loop_q) |-> (rx_valid == $past(line_valid)));

  assert_ones_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q && drv_valid) |-> (drv_pos ^ drv_neg));

  assert_ones_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q && drv_valid) |-> (drv_pos == !seen_pos));

  assert_data_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !ones_q && drv_valid) |-> (drv_neg == $past(tx_neg)));
endmodule

bind lbk_path_sel lbk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_pos(tx_pos), .tx_neg(tx_neg),
  .line_valid(line_valid), .rx_valid(rx_valid), .rx_pos(rx_pos),
  .drv_valid(drv_valid), .drv_pos(drv_pos), .drv_neg(drv_neg),
  .loop_q(loop_q), .ones_q(ones_q)
);

// File: tb/tb_lbk_path_sel.sv
module tb_lbk_path_sel;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_mode = 1'b1, pin_loop = 1'b0, pin_ones = 1'b0;
  logic [7:0] host_ctrl = '0;
  logic tx_valid = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0;
  logic line_valid = 1'b0, line_pos = 1'b0, line_neg = 1'b0;
  logic rx_valid, rx_pos, rx_neg, drv_valid, drv_pos, drv_neg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  // Bench model: sign of the last single-rail mark sent (R8), 0 after reset.
  bit last_pos = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbk_path_sel dut (
    .clk(clk), .rst_n(rst_n), .hw_mode(hw_mode), .pin_loop(pin_loop),
    .pin_ones(pin_ones), .host_ctrl(host_ctrl), .tx_valid(tx_valid),
    .tx_pos(tx_pos), .tx_neg(tx_neg), .line_valid(line_valid),
    .line_pos(line_pos), .line_neg(line_neg), .rx_valid(rx_valid),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .drv_valid(drv_valid),
    .drv_pos(drv_pos), .drv_neg(drv_neg)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One transmit bit (with an optional line bit in the same cycle);
  // expected outputs follow from the adopted loop/ones state.
  task automatic send_bit(input string req, input logic tp, input logic tn,
                          input logic lv, input logic lp, input logic ln,
                          input bit e_loop, input bit e_ones);
    logic [2:0] e_drv, e_rx;
    tx_valid = 1'b1; tx_pos = tp; tx_neg = tn;
    line_valid = lv; line_pos = lp; line_neg = ln;
    @(negedge clk);
    if (e_ones) e_drv = {1'b1, !last_pos, last_pos};
    else        e_drv = {1'b1, tp, tn};
    if (e_drv[1] ^ e_drv[0]) last_pos = e_drv[1];
    e_rx = e_loop ? {1'b1, tp, tn} : {lv, lp, ln};
    chk({req, " drv"}, {drv_valid, drv_pos, drv_neg}, e_drv);
    if (e_rx[2]) chk({req, " rx"}, {rx_valid, rx_pos, rx_neg}, e_rx);
    else         chk({req, " rx_valid"}, {2'b00, rx_valid}, 3'b000);
    tx_valid = 1'b0; line_valid = 1'b0;
  endtask

  task automatic line_only(input string req, input logic lp, input logic ln, input bit e_loop);
    line_valid = 1'b1; line_pos = lp; line_neg = ln;
    @(negedge clk);
    if (e_loop) chk({req, " rx_valid"}, {2'b00, rx_valid}, 3'b000);
    else        chk({req, " rx"}, {rx_valid, rx_pos, rx_neg}, {1'b1, lp, ln});
    chk({req, " drv_valid"}, {2'b00, drv_valid}, 3'b000);
    line_valid = 1'b0;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; last_pos = 1'b0;
    hw_mode = 1'b1; pin_loop = 1'b0; pin_ones = 1'b0; host_ctrl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;  // R1
    chk("R1 outputs", {rx_valid, rx_pos, rx_neg}, 3'b000);
    chk("R1 outputs", {drv_valid, drv_pos, drv_neg}, 3'b000);
  endtask

  task automatic t_first_ones;  // R1, R7, R10
    pin_ones = 1'b1;
    send_bit("R1 first mark", 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1);
    send_bit("R7 alternate", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 0, 1);
    send_bit("R7 alternate", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1);
    send_bit("R10 rx from line", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0, 1);
    pin_ones = 1'b0;
  endtask

  task automatic t_normal;  // R4, R6, R11
    send_bit("R6 data", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 0);
    send_bit("R4 line", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0);
    @(negedge clk);
    chk("R11 hold drv", {drv_valid, drv_pos, drv_neg}, 3'b001);
    chk("R11 hold rx", {rx_valid, rx_pos, rx_neg}, 3'b010);
  endtask

  task automatic t_loop_boundary;  // R3, R5, R6
    pin_loop = 1'b1;
    line_only("R3 not yet adopted", 1'b0, 1'b1, 0);
    send_bit("R5 loop", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1, 0);
    line_only("R5 line ignored", 1'b1, 1'b1, 1);
    chk("R5 rx held", {rx_valid, rx_pos, rx_neg}, 3'b010);
    send_bit("R6 loop still drives", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1, 0);
    pin_loop = 1'b0;
    line_only("R3 loop kept", 1'b1, 1'b0, 1);
    send_bit("R3 loop released", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 0, 0);
  endtask

  task automatic t_ones_after_data;  // R8
    send_bit("R8 data mark", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    send_bit("R8 no-mark bit", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    pin_ones = 1'b1;
    chk("R8 model", {2'b00, last_pos}, 3'b001);
    send_bit("R8 opposite start", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1);
    pin_ones = 1'b0;
    send_bit("R8 data neg", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0);
    pin_ones = 1'b1;
    send_bit("R8 after neg data", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 1);
    pin_ones = 1'b0;
    send_bit("R3 ones released", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_host;  // R2, R9
    hw_mode = 1'b0; pin_loop = 1'b1; pin_ones = 1'b1;
    send_bit("R2 pins ignored", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 0);
    host_ctrl = 8'h40;
    send_bit("R2 host loop", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1, 0);
    host_ctrl = 8'h20;
    send_bit("R2 host ones", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 1);
    host_ctrl = 8'h60;
    send_bit("R9 both", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1, 1);
    send_bit("R9 both", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1, 1);
    host_ctrl = 8'h9F;
    send_bit("R2 other bits", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 0, 0);
    hw_mode = 1'b1;
    send_bit("R2 back to pins", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1, 1);
    pin_loop = 1'b0; pin_ones = 1'b0;
  endtask

  initial begin
    do_reset();
    t_reset();
    t_first_ones();
    t_normal();
    t_loop_boundary();
    t_ones_after_data();
    t_host();
    do_reset();
    t_reset();
    t_first_ones();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule